// File: doc/BRIEF.md
# Second-Chance Victim Selector

This block chooses which physical frame to evict when a new page must be brought in. It keeps one use bit and one dirty bit for each frame, and a circular pointer that marks the oldest frame. Access events set a frame's use bit, and a write access also sets its dirty bit. A clean event reports that the frame's contents have been written out, and it clears the dirty bit. When a selection is requested, the block examines one frame per clock, starting at the oldest. It answers with a one-cycle done pulse, the victim's index, and a flag that says whether the victim must be written back first.

The block has two scan policies, chosen when the request is accepted:

- **Plain second chance.** A used frame loses its use bit and is passed over. The first unused frame becomes the victim.
- **Class-ordered scan.** The block sweeps the frames up to four times, once for each use/dirty class from most to least attractive, and leaves the bits untouched. If no frame matches in any sweep, the scan continues in plain second-chance mode.

After a choice, the pointer moves just past the victim, so the new page counts as the youngest entry. The victim's bits are also cleared.

Top module: `sc_victim_sel`

## Requirements
- R1: After reset the block is idle with doneStb low and busy low. Every use and dirty bit is clear and the pointer is at frame 0, so the first plain select returns frame 0 after one examined frame.
- R2: An access event (accValid) sets the use bit of frame accIdx on the next edge. When accWrite is also high, the event sets that frame's dirty bit as well.
- R3: A clean event (cleanValid) clears the dirty bit of frame cleanIdx. A write access to the same frame in the same cycle wins, and the dirty bit stays set.
- R4: Plain mode (enhMode low at the request) examines frames in circular order from the pointer. A frame whose use bit is set has the bit cleared and is passed over. The first frame found with its use bit clear is the victim.
- R5: Class-ordered mode (enhMode high at the request) ranks each frame by class = {use, dirty}. Class 0 is best and class 3 is worst. Sweep k (k = 0..3) covers all NUM_FRAMES frames in circular order from the pointer, and the first frame whose class equals k is the victim. No use bit is cleared during these sweeps.
- R6: If four class sweeps end without a match, the scan continues in plain mode from the pointer.
- R7: The result is reported with doneStb high for exactly one cycle, together with victimIdx and victimDirty. victimDirty is the victim's dirty bit before eviction. busy is low in the cycle where doneStb is high.
- R8: After a victim is chosen, the pointer moves to victimIdx+1, wrapping to 0 after the last frame. The victim's use and dirty bits are cleared.
- R9: The scan examines exactly one frame per clock. busy rises on the edge that accepts selReq while idle. doneStb appears k cycles after that, where k is the number of frames examined.
- R10: If an access event targets the frame whose use bit the scan clears in the same cycle, the use bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enhMode | input | 1 | Scan policy, sampled with an accepted request: 1 selects class-ordered |
| selReq | input | 1 | Request a victim; taken only when busy is low |
| accValid | input | 1 | Access event for frame accIdx |
| accWrite | input | 1 | Qualifies the access as a write |
| accIdx | input | $clog2(NUM_FRAMES) | Frame touched by the access |
| cleanValid | input | 1 | Clean event for frame cleanIdx |
| cleanIdx | input | $clog2(NUM_FRAMES) | Frame whose contents were written out |
| busy | output | 1 | A scan is in progress |
| doneStb | output | 1 | One-cycle pulse: victim outputs are valid |
| victimIdx | output | $clog2(NUM_FRAMES) | Chosen frame |
| victimDirty | output | 1 | The chosen frame needs write-back |

## Verification
Two updates can land on the same frame in the same clock, and the bench forces each of them deliberately.

**Access versus scan clear.** An access event can arrive in the very cycle in which a plain scan clears that frame's use bit. The bench sets every use bit and then injects an access to the oldest frame exactly on the first scan edge. If the access wins, the frame survives one more full lap. The victim is then the next frame, reported after NUM_FRAMES+2 examined frames.

**Write versus clean.** A write access and a clean event can target the same frame together. The bench drives both at once and then makes that frame the victim, expecting victimDirty high.

**Cleans during a class sweep.** The bench also issues a clean in the cycle each frame is examined during the third class sweep. This drives the scan through all four sweeps into the plain fallback, with a latency of 5*NUM_FRAMES+1.

// File: rtl/scv_pkg.sv
package scv_pkg;

  // Strobes issued by the scan control to the frame-state datapath
  typedef struct packed {
    logic loadCur;   // copy pointer into scan cursor
    logic stepCur;   // advance cursor by one frame (circular)
    logic clearUse;  // clear use bit of the frame under the cursor
    logic commit;    // frame under cursor is the victim
  } scStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENH   = 2'd1,
    ST_BASIC = 2'd2
  } scState_e;

endpackage

// File: rtl/sc_victim_dp.sv
module sc_victim_dp #(
  parameter int NUM_FRAMES = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  scv_pkg::scStrobe_t              strobe,
  input  logic                            accValid,
  input  logic                            accWrite,
  input  logic [$clog2(NUM_FRAMES)-1:0]   accIdx,
  input  logic                            cleanValid,
  input  logic [$clog2(NUM_FRAMES)-1:0]   cleanIdx,
  output logic                            curUse,
  output logic                            curDirty,
  output logic [$clog2(NUM_FRAMES)-1:0]   victimIdx,
  output logic                            victimDirty
);
  localparam int IDX_W = $clog2(NUM_FRAMES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  logic [NUM_FRAMES-1:0] useQ, dirtyQ;
  logic [NUM_FRAMES-1:0] useNext, dirtyNext;
  logic [IDX_W-1:0]      ptrQ, curQ, curInc;

  assign curInc   = (curQ == LAST_IDX) ? '0 : curQ + 1'b1;
  assign curUse   = useQ[curQ];
  assign curDirty = dirtyQ[curQ];

  // Per-frame next state: external events take priority over scan clears
  for (genvar i = 0; i < NUM_FRAMES; i++) begin : gFrame
    logic hitCur, hitAcc, hitClean;
    assign hitCur   = (curQ == IDX_W'(i));
    assign hitAcc   = accValid && (accIdx == IDX_W'(i));
    assign hitClean = cleanValid && (cleanIdx == IDX_W'(i));
    assign useNext[i] = hitAcc ? 1'b1 :
                        ((strobe.clearUse || strobe.commit) && hitCur) ? 1'b0 : useQ[i];
    assign dirtyNext[i] = (hitAcc && accWrite) ? 1'b1 :
                          ((strobe.commit && hitCur) || hitClean) ? 1'b0 : dirtyQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      useQ        <= '0;
      dirtyQ      <= '0;
      ptrQ        <= '0;
      curQ        <= '0;
      victimIdx   <= '0;
      victimDirty <= 1'b0;
    end else begin
      useQ   <= useNext;
      dirtyQ <= dirtyNext;
      if (strobe.loadCur)      curQ <= ptrQ;
      else if (strobe.stepCur) curQ <= curInc;
      if (strobe.commit) begin
        ptrQ        <= curInc;
        victimIdx   <= curQ;
        victimDirty <= dirtyQ[curQ];
      end
    end
  end

  AST_ACCESS_SETS_USE: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> useQ[$past(accIdx)]); // R10

  AST_WRITE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accWrite |=> dirtyQ[$past(accIdx)]); // R2

  AST_CLEAN_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    cleanValid && !(accValid && accWrite && accIdx == cleanIdx)
    |=> !dirtyQ[$past(cleanIdx)]); // R3

  AST_VICTIM_BITS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit && !(accValid && accIdx == curQ)
    |=> !useQ[$past(curQ)] && !dirtyQ[$past(curQ)]); // R8

endmodule

// File: rtl/sc_victim_ctl.sv
module sc_victim_ctl #(
  parameter int NUM_FRAMES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enhMode,
  input  logic               selReq,
  input  logic               curUse,
  input  logic               curDirty,
  output scv_pkg::scStrobe_t strobe,
  output logic               busy,
  output logic               doneStb
);
  import scv_pkg::*;

  localparam int IDX_W = $clog2(NUM_FRAMES);
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(NUM_FRAMES - 1);

  scState_e         stateQ, stateN;
  logic [1:0]       passQ, passN;    // class searched in the current sweep
  logic [IDX_W-1:0] stepQ, stepN;    // frames seen in the current sweep
  logic             doneN;

  always_comb begin
    strobe = '0;
    stateN = stateQ;
    passN  = passQ;
    stepN  = stepQ;
    doneN  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (selReq) begin
          strobe.loadCur = 1'b1;
          stateN = enhMode ? ST_ENH : ST_BASIC;
          passN  = 2'd0;
          stepN  = '0;
        end
      end
      ST_ENH: begin
        if ({curUse, curDirty} == passQ) begin
          strobe.commit = 1'b1;
          doneN  = 1'b1;
          stateN = ST_IDLE;
        end else begin
          strobe.stepCur = 1'b1;
          if (stepQ == LAST_STEP) begin
            stepN = '0;
            if (passQ == 2'd3) stateN = ST_BASIC;
            else               passN  = passQ + 2'd1;
          end else begin
            stepN = stepQ + 1'b1;
          end
        end
      end
      ST_BASIC: begin
        if (curUse) begin
          strobe.clearUse = 1'b1;
          strobe.stepCur  = 1'b1;
        end else begin
          strobe.commit = 1'b1;
          doneN  = 1'b1;
          stateN = ST_IDLE;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      passQ   <= 2'd0;
      stepQ   <= '0;
      doneStb <= 1'b0;
    end else begin
      stateQ  <= stateN;
      passQ   <= passN;
      stepQ   <= stepN;
      doneStb <= doneN;
    end
  end

  assign busy = (stateQ != ST_IDLE);

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb); // R7

  AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> !busy); // R7

  AST_REQ_STARTS_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    selReq && !busy |=> busy); // R9

endmodule

// File: rtl/sc_victim_sel.sv
module sc_victim_sel #(
  parameter int NUM_FRAMES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enhMode,
  input  logic                          selReq,
  input  logic                          accValid,
  input  logic                          accWrite,
  input  logic [$clog2(NUM_FRAMES)-1:0] accIdx,
  input  logic                          cleanValid,
  input  logic [$clog2(NUM_FRAMES)-1:0] cleanIdx,
  output logic                          busy,
  output logic                          doneStb,
  output logic [$clog2(NUM_FRAMES)-1:0] victimIdx,
  output logic                          victimDirty
);
  scv_pkg::scStrobe_t strobe;
  logic curUse, curDirty;

  sc_victim_ctl #(.NUM_FRAMES(NUM_FRAMES)) uCtl (
    .clk(clk), .rstN(rstN), .enhMode(enhMode), .selReq(selReq),
    .curUse(curUse), .curDirty(curDirty), .strobe(strobe),
    .busy(busy), .doneStb(doneStb)
  );

  sc_victim_dp #(.NUM_FRAMES(NUM_FRAMES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .accValid(accValid), .accWrite(accWrite), .accIdx(accIdx),
    .cleanValid(cleanValid), .cleanIdx(cleanIdx),
    .curUse(curUse), .curDirty(curDirty),
    .victimIdx(victimIdx), .victimDirty(victimDirty)
  );

endmodule

// File: tb/sc_victim_sel_test.sv
module sc_victim_sel_test;
  localparam int N        = 8;
  localparam int IW       = $clog2(N);
  localparam int CLK_HALF = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic enhMode = 1'b0, selReq = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0, cleanValid = 1'b0;
  logic [IW-1:0] accIdx = '0, cleanIdx = '0;
  logic busy, doneStb, victimDirty;
  logic [IW-1:0] victimIdx;

  always #CLK_HALF clk = ~clk;

  sc_victim_sel #(.NUM_FRAMES(N)) uut (
    .clk(clk), .rstN(rstN), .enhMode(enhMode), .selReq(selReq),
    .accValid(accValid), .accWrite(accWrite), .accIdx(accIdx),
    .cleanValid(cleanValid), .cleanIdx(cleanIdx),
    .busy(busy), .doneStb(doneStb), .victimIdx(victimIdx), .victimDirty(victimDirty)
  );

  typedef struct { int idx; int dirty; int lat; string tag; } exp_t;
  exp_t expQ[$];
  int nChk = 0, nFail = 0;
  bit mUse[N], mDirty[N];
  int mPtr = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  // Reference model of the selection rules
  task automatic basicScan(inout int lat, output int v);
    int c = mPtr;
    forever begin
      lat++;
      if (mUse[c]) begin mUse[c] = 0; c = (c + 1) % N; end
      else break;
    end
    v = c;
  endtask

  task automatic modelSelect(input bit enh, input string tag);
    exp_t e;
    int v = 0, lat = 0;
    bit found = 0;
    if (enh) begin
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < N; s++) begin
          int c = (mPtr + s) % N;
          if (!found && (int'({mUse[c], mDirty[c]}) == k)) begin
            found = 1; v = c; lat = k * N + s + 1;
          end
        end
      if (!found) begin lat = 4 * N; basicScan(lat, v); end
    end else basicScan(lat, v);
    e.idx = v; e.dirty = mDirty[v]; e.lat = lat; e.tag = tag;
    expQ.push_back(e);
    mUse[v] = 0; mDirty[v] = 0; mPtr = (v + 1) % N;
  endtask

  // Driver
  task automatic waitDone();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doSelect(input bit enh, input string tag);
    modelSelect(enh, tag);
    @(negedge clk); selReq = 1; enhMode = enh;
    @(negedge clk); selReq = 0;
    waitDone();
  endtask

  task automatic access(input int f, input bit wr);
    @(negedge clk); accValid = 1; accWrite = wr; accIdx = IW'(f);
    @(negedge clk); accValid = 0; accWrite = 0;
    mUse[f] = 1; if (wr) mDirty[f] = 1;
  endtask

  task automatic clean(input int f);
    @(negedge clk); cleanValid = 1; cleanIdx = IW'(f);
    @(negedge clk); cleanValid = 0;
    mDirty[f] = 0;
  endtask

  task automatic writeAndClean(input int f);
    @(negedge clk); accValid = 1; accWrite = 1; accIdx = IW'(f);
    cleanValid = 1; cleanIdx = IW'(f);
    @(negedge clk); accValid = 0; accWrite = 0; cleanValid = 0;
    mUse[f] = 1; mDirty[f] = 1;
  endtask

  // Monitor / scoreboard
  int cyc = 0, startCyc = 0;
  bit prevBusy = 0, prevDone = 0;
  exp_t got;
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (busy && !prevBusy) startCyc = cyc;
      if (prevDone) chk("R7", "doneStb width", int'(doneStb), 0);
      if (doneStb) begin
        if (expQ.size() == 0) chk("R7", "unexpected done", 1, 0);
        else begin
          got = expQ.pop_front();
          chk(got.tag, "victimIdx", int'(victimIdx), got.idx);
          chk(got.tag, "victimDirty", int'(victimDirty), got.dirty);
          chk("R9", "scan cycles", cyc - startCyc, got.lat);
          chk("R7", "busy at done", int'(busy), 0);
        end
      end
      prevBusy = busy; prevDone = doneStb;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", "timeout", 1, 0);
    finish_run();
  end

  initial begin
    int p;
    exp_t e;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "doneStb after reset", int'(doneStb), 0);
    doSelect(0, "R1/R8");

    // R10: access collides with use-bit clear on the first examined frame
    for (int f = 0; f < N; f++) access(f, 0);
    p = mPtr;
    e.idx = (p + 1) % N; e.dirty = 0; e.lat = N + 2; e.tag = "R10";
    expQ.push_back(e);
    for (int f = 0; f < N; f++) mUse[f] = 0;
    mPtr = (p + 2) % N;
    @(negedge clk); selReq = 1; enhMode = 0;
    @(negedge clk); selReq = 0; accValid = 1; accWrite = 0; accIdx = IW'(p);
    @(negedge clk); accValid = 0;
    waitDone();

    // R4: plain second chance with a mix of used frames
    access((mPtr + 0) % N, 0); access((mPtr + 1) % N, 1); access((mPtr + 3) % N, 0);
    doSelect(0, "R4");
    doSelect(0, "R4");

    // R2/R5: class-ordered choice
    access((mPtr + 0) % N, 1); access((mPtr + 2) % N, 0);
    for (int f = 0; f < N; f++) if (f != (mPtr + 4) % N) access(f, 1);
    doSelect(1, "R5");
    clean((mPtr + 2) % N);
    doSelect(1, "R5");
    doSelect(1, "R2");

    // R3: write and clean on one frame in one cycle; write wins
    p = mPtr;
    for (int f = 0; f < N; f++) if (f != p) access(f, 0);
    writeAndClean(p);
    doSelect(0, "R3");
    access(mPtr, 1); clean(mPtr);
    for (int f = 0; f < N; f++) access(f, 0);
    doSelect(0, "R3");

    // R6: cleans during sweep 2 defeat every class sweep
    for (int f = 0; f < N; f++) access(f, 1);
    p = mPtr;
    e.idx = p; e.dirty = 0; e.lat = 5 * N + 1; e.tag = "R6";
    expQ.push_back(e);
    for (int f = 0; f < N; f++) begin mUse[f] = 0; mDirty[f] = 0; end
    mPtr = (p + 1) % N;
    @(negedge clk); selReq = 1; enhMode = 1;
    @(negedge clk); selReq = 0;
    repeat (2 * N) @(negedge clk);
    for (int j = 0; j < N; j++) begin
      cleanValid = 1; cleanIdx = IW'((p + j) % N);
      @(negedge clk);
    end
    cleanValid = 0;
    waitDone();

    // Mixed patterns in both modes (R4, R5, R8)
    for (int t = 0; t < 12; t++) begin
      for (int f = 0; f < N; f++) begin
        int v = (t * 5 + f * 3) % 7;
        if (v == 0) access(f, 0);
        else if (v == 1 || v == 4) access(f, 1);
        else if (v == 2) clean(f);
      end
      doSelect(t[0], t[0] ? "R5" : "R4");
      doSelect(t[1], "R8");
    end

    repeat (3) @(negedge clk);
    chk("R7", "pending results", expQ.size(), 0);
    finish_run();
  end

endmodule